// File: doc/BRIEF.md
# Round-Robin Batch Distributor

This block takes a single ordered stream of opaque work words from one upstream port and hands them out to a set of downstream processing units. The units are served in a fixed rotating order. Each unit receives a run of consecutive items of a fixed length, called a batch, and then the distributor moves on to the next unit.

After the last item of every batch, the distributor sends a one-beat switch marker on the same output channel. A merge stage further down can then tell that this unit's share is complete, and it can rebuild the original item order by visiting the units in the same rotation.

Every output lane has its own valid/ready pair. If the lane now selected is not ready, the whole distributor waits. It never skips to another unit. A flush input lets upstream close a partly filled batch early.

Top module: `rr_batch_dist`

## Requirements
- R1: Units are served in the order 0, 1, ..., NUM_OUT-1 and then 0 again. The distributor moves to the next unit in the clock edge at which a switch marker is accepted.
- R2: A unit receives exactly BATCH accepted items, with a default of 2, before its switch marker is sent. A flush can end the batch sooner.
- R3: A switch marker is a beat on the selected lane with `out_marker` bit high and the data slice zero. While a marker is pending, `in_ready` is low.
- R4: Items leave on the selected lane in the order they were accepted, and their data is unchanged.
- R5: When the selected lane's `out_ready` is low, `in_ready` is low and the beat stays on that lane. No other lane is served.
- R6: When `in_flush` is high in a cycle where the batch holds at least one item, counting an item accepted in that same cycle, a switch marker follows from the next cycle on, and the unit then advances.
- R7: When `in_flush` is high while the batch is empty, it has no effect. The next item goes to the same unit.
- R8: After reset, distribution starts at unit 0 with an empty batch.
- R9: At most one bit of `out_valid` is high in any cycle.
- R10: An item appears on the selected lane in the same cycle as it is presented. A marker appears in the cycle after the accepting edge of the batch's last item or of the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Upstream item present |
| in_data | input | DATA_W | Upstream item payload |
| in_flush | input | 1 | Close the current partial batch |
| in_ready | output | 1 | Upstream item accepted this cycle when high with in_valid |
| out_valid | output | NUM_OUT | Per-lane beat present |
| out_marker | output | NUM_OUT | Per-lane tag: 1 = switch marker, 0 = item |
| out_data | output | NUM_OUT*DATA_W | Lane i payload at bits [i*DATA_W +: DATA_W] |
| out_ready | input | NUM_OUT | Per-lane downstream ready |

## Verification
Items pass through with no register on the way. The selected lane's valid and data, and `in_ready`, are therefore due in the same cycle the stimulus is driven. The bench drives inputs just after a falling edge and compares two time units later, still before the next rising edge. A marker is due one rising edge after the last item or flush is taken, and the unit advances one edge after the marker is taken. The bench's reference state is updated only once per cycle, after each comparison, so every expected value refers to the edges that have already happened.

// File: rtl/rr_batch_dist_pkg.sv
package rr_batch_dist_pkg;

    // Whether the selected lane is taking items or owes a switch marker
    typedef enum logic {
        PH_ITEMS = 1'b0,
        PH_MARK  = 1'b1
    } dist_phase_e;

endpackage

// File: rtl/rr_batch_ctrl.sv
module rr_batch_ctrl
    import rr_batch_dist_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int BATCH   = 2,
    localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
    localparam int CNT_W  = $clog2(BATCH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_flush,
    input  logic [NUM_OUT-1:0] out_ready,
    output logic [SEL_W-1:0]   sel,
    output logic               mark_pending,
    output logic               in_ready
);

    typedef struct packed {
        dist_phase_e      phase;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    logic             sel_rdy;
    logic             take_item;
    logic             take_mark;
    logic [CNT_W-1:0] cnt_nx;

    always_comb begin
        st_d      = st_q;
        sel_rdy   = out_ready[st_q.sel];
        take_item = (st_q.phase == PH_ITEMS) && in_valid && sel_rdy;
        take_mark = (st_q.phase == PH_MARK) && sel_rdy;
        cnt_nx    = st_q.cnt + CNT_W'(take_item);

        if (take_mark) begin
            st_d.phase = PH_ITEMS;
            st_d.cnt   = '0;
            st_d.sel   = (st_q.sel == SEL_W'(NUM_OUT - 1)) ? '0 : st_q.sel + 1'b1;
        end else if (st_q.phase == PH_ITEMS) begin
            st_d.cnt = cnt_nx;
            if ((take_item && cnt_nx == CNT_W'(BATCH)) ||
                (in_flush && cnt_nx != '0)) begin
                st_d.phase = PH_MARK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_ITEMS, sel: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel          = st_q.sel;
    assign mark_pending = (st_q.phase == PH_MARK);
    assign in_ready     = (st_q.phase == PH_ITEMS) && sel_rdy;

endmodule

// File: rtl/rr_lane_demux.sv
module rr_lane_demux #(
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16,
    localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic [SEL_W-1:0]          sel,
    input  logic                      mark_pending,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    output logic [NUM_OUT-1:0]        out_valid,
    output logic [NUM_OUT-1:0]        out_marker,
    output logic [NUM_OUT*DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] beat_data;

    assign beat_data = mark_pending ? '0 : in_data;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        logic hit;
        assign hit                       = (sel == SEL_W'(i));
        assign out_valid[i]              = hit && (mark_pending || in_valid);
        assign out_marker[i]             = hit && mark_pending;
        assign out_data[i*DATA_W +: DATA_W] = beat_data;
    end

endmodule

// File: rtl/rr_batch_dist.sv
module rr_batch_dist #(
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16,
    parameter int BATCH   = 2,
    localparam int SEL_W  = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    input  logic                      in_flush,
    output logic                      in_ready,
    output logic [NUM_OUT-1:0]        out_valid,
    output logic [NUM_OUT-1:0]        out_marker,
    output logic [NUM_OUT*DATA_W-1:0] out_data,
    input  logic [NUM_OUT-1:0]        out_ready
);

    logic [SEL_W-1:0] sel;
    logic             mark_pending;

    rr_batch_ctrl #(
        .NUM_OUT (NUM_OUT),
        .BATCH   (BATCH)
    ) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_flush     (in_flush),
        .out_ready    (out_ready),
        .sel          (sel),
        .mark_pending (mark_pending),
        .in_ready     (in_ready)
    );

    rr_lane_demux #(
        .NUM_OUT (NUM_OUT),
        .DATA_W  (DATA_W)
    ) demux_i (
        .sel          (sel),
        .mark_pending (mark_pending),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .out_valid    (out_valid),
        .out_marker   (out_marker),
        .out_data     (out_data)
    );

endmodule

// File: rtl/rr_batch_dist_chk.sv
module rr_batch_dist_chk #(
    parameter int NUM_OUT = 4,
    parameter int DATA_W  = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic [NUM_OUT-1:0]        out_valid,
    input logic [NUM_OUT-1:0]        out_marker,
    input logic [NUM_OUT*DATA_W-1:0] out_data,
    input logic [NUM_OUT-1:0]        out_ready
);

    p_onehot_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_valid));

    p_marker_blocks_input_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(out_valid & out_marker)) |-> !in_ready);

    p_accept_has_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> ($countones(out_valid & out_ready & ~out_marker) == 1));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane_chk
        p_marker_is_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_marker[i] |-> (out_valid[i] && out_data[i*DATA_W +: DATA_W] == '0));

        p_marker_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[i] && out_marker[i] && !out_ready[i]) |=> (out_valid[i] && out_marker[i]));

        if (NUM_OUT > 1) begin : g_multi
            p_advance_after_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid[i] && out_marker[i] && out_ready[i]) |=> !out_valid[i]);
        end
    end

endmodule

bind rr_batch_dist rr_batch_dist_chk #(
    .NUM_OUT (NUM_OUT),
    .DATA_W  (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_marker (out_marker),
    .out_data   (out_data),
    .out_ready  (out_ready)
);

// File: tb/rr_batch_dist_tb_top.sv
`timescale 1ns/1ps
module rr_batch_dist_tb_top;

    localparam int N = 4;
    localparam int W = 16;
    localparam int B = 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [W-1:0]     in_data;
    logic             in_flush;
    logic             in_ready;
    logic [N-1:0]     out_valid;
    logic [N-1:0]     out_marker;
    logic [N*W-1:0]   out_data;
    logic [N-1:0]     out_ready;

    always #4 clk = ~clk;

    rr_batch_dist #(.NUM_OUT(N), .DATA_W(W), .BATCH(B)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_flush(in_flush), .in_ready(in_ready), .out_valid(out_valid),
        .out_marker(out_marker), .out_data(out_data), .out_ready(out_ready)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    int          m_sel = 0;
    int          m_cnt = 0;
    bit          m_mark = 1'b0;
    logic [W-1:0] nxt_data = 16'h0100;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare, then advance the reference
    task automatic step(bit v, bit f, logic [N-1:0] rdy, string tag);
        logic [N-1:0] ev, em;
        bit           eir, acc;
        string        t;
        @(negedge clk);
        in_valid  = v;
        in_flush  = f;
        out_ready = rdy;
        in_data   = nxt_data;
        #2;
        t   = m_mark ? {tag, "/R3"} : tag;
        ev  = (m_mark || v) ? (N'(1) << m_sel) : '0;
        em  = m_mark ? (N'(1) << m_sel) : '0;
        eir = !m_mark && rdy[m_sel];
        chk(out_valid == ev, t, "R9 lane valid", out_valid, ev);
        chk(out_marker == em, t, "marker tag", out_marker, em);
        chk(in_ready == eir, t, "in_ready", in_ready, eir);
        if (ev != '0)
            chk(out_data[m_sel*W +: W] == (m_mark ? '0 : nxt_data), t, "R10 same-cycle data",
                out_data[m_sel*W +: W], m_mark ? 0 : nxt_data);
        acc = !m_mark && v && rdy[m_sel];
        if (m_mark) begin
            if (rdy[m_sel]) begin
                m_mark = 1'b0;
                m_cnt  = 0;
                m_sel  = (m_sel + 1) % N;
            end
        end else begin
            if (acc) begin
                m_cnt++;
                nxt_data++;
            end
            if ((acc && m_cnt == B) || (f && m_cnt != 0)) m_mark = 1'b1;
        end
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_flush = 1'b0; in_data = '0; out_ready = '1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: idle after reset, then the first batch lands on unit 0
        step(1'b0, 1'b0, '1, "R8");
        step(1'b1, 1'b0, '1, "R8");

        // R1 R2 R4: steady stream, wraps the rotation several times
        for (int k = 0; k < 30; k++) step(1'b1, 1'b0, '1, "R1");

        // R5: selected lane stalled with an item, then with a marker
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, ~(N'(1) << m_sel), "R5");
        step(1'b1, 1'b0, '1, "R5");
        for (int k = 0; k < 3; k++) step(1'b1, 1'b0, ~(N'(1) << m_sel), "R5");
        step(1'b1, 1'b0, '1, "R5");

        // R6: flush together with the first item, and flush after one item
        while (m_mark || m_cnt != 0) step(1'b0, 1'b0, '1, "R6");
        step(1'b1, 1'b1, '1, "R6");
        step(1'b0, 1'b0, '1, "R6");
        step(1'b1, 1'b0, '1, "R6");
        step(1'b0, 1'b1, '1, "R6");
        step(1'b0, 1'b0, '1, "R6");

        // R7: flush on an empty batch leaves the unit unchanged
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, '1, "R7");
        step(1'b1, 1'b0, '1, "R7");
        step(1'b1, 1'b0, '1, "R7");

        // R5 sweep: every ready mask held for several cycles
        for (int m = 0; m < (1 << N); m++)
            for (int k = 0; k < 6; k++) step(1'b1, 1'b0, N'(m), "R5");

        // R4: pseudo-random valid, flush and ready patterns
        for (int k = 0; k < 3000; k++)
            step(lf[0] | lf[1], lf[7:4] == 4'h0, lf[11:8] | lf[15:12], "R4");

        summary();
    end

endmodule